// File: doc/BRIEF.md
# Programmable Clock Divider Generator

A register-programmed clock generator with two output channels. Each channel picks one of eight source inputs, divides it by an integer from 1 to 256, and can bypass the divider or invert its output. Everything runs in one system clock domain. Each source arrives as a level signal that is sampled on the system clock, and a source "tick" is a rising edge of the sampled, optionally inverted level. The channel outputs are level signals built from registers, so downstream logic treats them as slow clock-enable waveforms rather than true clocks.

A shared control word holds a global divider run bit, one inversion bit per source input, and two clock-gate modes. The bus-clock gate mode is two bits with one reserved code. The peripheral-clock gate mode is one bit. When a gate is in dynamic mode it follows the `bus_busy` input.

Software reaches the control word and the channel configuration words through a plain single-cycle register port. The port has a write strobe and a combinational read. This is control traffic, so it has no valid/ready handshake and never applies back-pressure. A write always lands on the clock edge where `reg_we` is high. A new divisor or source takes effect only when the running period ends, so no output pulse is ever cut short.

Top module: `clkgen_top`

## Requirements
- R1: After synchronous reset every register reads 0, both `clk_out` bits are 0, and `bclk_en` is 0.
- R2: Channel c's configuration sits at word address 2*c (words 0 and 2), and the control word sits at word 4. Every other word reads 0, and a write to it changes no register.
- R3: Configuration fields read back as written: bit 0 bypass, bit 1 output invert, bits [4:2] source select, bits [12:5] divisor minus one. Control fields read back as written: bits [1:0] bus-clock mode, bit 2 run, bit 3 peripheral-clock mode, bits [11:4] per-source input invert. Unused bits read 0.
- R4: For an even divisor N = field+1, the output is high for N/2 source periods and low for N/2. This covers N=256 (field 255).
- R5: For an odd divisor N>1, the output is high for (N+1)/2 source periods and low for (N-1)/2. With N=1 the output copies the selected source level one cycle later.
- R6: The source select field chooses which input a channel counts, and the two channels run independently.
- R7: Control bit 4+i inverts source i before it is selected or edge-detected.
- R8: Configuration bit 1 inverts the channel output.
- R9: Configuration bit 0 set makes the output the selected (input-inverted) source level delayed one cycle, whatever the run bit is.
- R10: With control bit 2 clear, the divided output and its count hold. Setting the bit again resumes division.
- R11: A change to a divisor or source field is used only from the next terminal count on, so the period in progress ends at its old length.
- R12: `bclk_en` is 0 for bus modes 0 and 1, follows `bus_busy` in mode 2, and is 1 in mode 3.
- R13: `pclk_en` is 1 when control bit 3 is set, and otherwise follows `bus_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| src_in | input | 8 | Source levels, sampled on `clk` |
| bus_busy | input | 1 | Activity hint for the dynamic gate modes |
| clk_out | output | 2 | Channel output levels |
| bclk_en | output | 1 | Bus-clock gate enable |
| pclk_en | output | 1 | Peripheral-clock gate enable |

## Verification
Wrong internal state shows up at the ports within one output period. A counter or shadow divisor that is off, or loaded at the wrong time, changes the measured high or low length of `clk_out` on the first full period after synchronization, or on the period that straddles a reconfiguration. Stale edge history or wrong input inversion shows up right away in the N=1 and bypass duty cycles, which reflect single source ticks. Register decode faults appear on the next read of `reg_rdata`, and gate-mode faults appear in the same cycle on `bclk_en` and `pclk_en`.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  // Configuration word bit positions (fields a channel decodes)
  localparam int CFG_BYP     = 0;
  localparam int CFG_OINV    = 1;
  localparam int CFG_SEL_LSB = 2;
  // Control word bit positions
  localparam int CTL_BMODE_LSB = 0;
  localparam int CTL_RUN       = 2;
  localparam int CTL_PMODE     = 3;
  localparam int CTL_IINV_LSB  = 4;

  typedef enum logic [1:0] {
    BUS_OFF  = 2'd0,
    BUS_RSVD = 2'd1,
    BUS_DYN  = 2'd2,
    BUS_ON   = 2'd3
  } bus_mode_e;
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs #(
  parameter int NUM_CH  = 2,
  parameter int NUM_SRC = 8,
  parameter int DIV_W   = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic [4+NUM_SRC-1:0]     ctl_q,
  output logic [NUM_CH*(2+$clog2(NUM_SRC)+DIV_W)-1:0] cfg_q
);
  localparam int SEL_W     = $clog2(NUM_SRC);
  localparam int CFG_W     = 2 + SEL_W + DIV_W;
  localparam int CTL_W     = 4 + NUM_SRC;
  localparam int CTRL_WORD = 2 * NUM_CH;
  localparam int USED_W    = (CTL_W > CFG_W) ? CTL_W : CFG_W;

  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:USED_W];

  // Control word
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (we && addr == ADDR_W'(CTRL_WORD)) begin
      ctl_q <= wdata[CTL_W-1:0];
    end
  end

  // One configuration word per channel, at even word slots
  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[c*CFG_W +: CFG_W] <= '0;
      end else if (we && addr == ADDR_W'(2*c)) begin
        cfg_q[c*CFG_W +: CFG_W] <= wdata[CFG_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_WORD)) rdata[CTL_W-1:0] = ctl_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(2*c)) rdata[CFG_W-1:0] = cfg_q[c*CFG_W +: CFG_W];
    end
  end
endmodule

// File: rtl/clkgen_src_cond.sv
module clkgen_src_cond #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] inv,
  output logic [NUM_SRC-1:0] lvl,
  output logic [NUM_SRC-1:0] tick
);
  logic [NUM_SRC-1:0] lvl_q;

  // Edge history is kept for every input, so switching sources later
  // never compares against a stale sample.
  assign lvl  = src_in ^ inv;
  assign tick = lvl & ~lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end
endmodule

// File: rtl/clkgen_divider.sv
module clkgen_divider #(
  parameter int NUM_SRC = 8,
  parameter int DIV_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       run,
  input  logic [NUM_SRC-1:0]         lvl,
  input  logic [NUM_SRC-1:0]         tick,
  input  logic [$clog2(NUM_SRC)-1:0] cfg_sel,
  input  logic [DIV_W-1:0]           cfg_divm1,
  output logic                       div_o,
  output logic                       byp_o
);
  localparam int SEL_W = $clog2(NUM_SRC);

  logic [SEL_W-1:0] sh_sel;
  logic [DIV_W-1:0] sh_divm1;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   hi_len;
  logic [DIV_W:0]   cnt_inc;
  logic             sel_tick;
  logic             term;
  logic             by_one;

  // High phase lasts ceil(N/2) ticks, N = sh_divm1 + 1
  assign hi_len   = ({1'b0, sh_divm1} + (DIV_W+1)'(2)) >> 1;
  assign cnt_inc  = {1'b0, cnt} + (DIV_W+1)'(1);
  assign sel_tick = tick[sh_sel];
  assign term     = (cnt == sh_divm1);
  assign by_one   = (sh_divm1 == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_o <= 1'b0;
    end else begin
      byp_o <= lvl[cfg_sel];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_sel   <= '0;
      sh_divm1 <= '0;
      cnt      <= '0;
      div_o    <= 1'b0;
    end else if (run) begin
      if (by_one) begin
        div_o <= lvl[sh_sel];
        if (sel_tick) begin
          sh_sel   <= cfg_sel;
          sh_divm1 <= cfg_divm1;
          cnt      <= '0;
        end
      end else if (sel_tick) begin
        if (term) begin
          cnt      <= '0;
          sh_sel   <= cfg_sel;
          sh_divm1 <= cfg_divm1;
          div_o    <= 1'b1;
        end else begin
          cnt   <= cnt_inc[DIV_W-1:0];
          div_o <= (cnt_inc < hi_len);
        end
      end
    end
  end
endmodule

// File: rtl/clkgen_gate.sv
module clkgen_gate
  import clkgen_pkg::*;
(
  input  logic [1:0] bmode,
  input  logic       pmode,
  input  logic       bus_busy,
  output logic       bclk_en,
  output logic       pclk_en
);
  bus_mode_e mode;
  assign mode = bus_mode_e'(bmode);

  always_comb begin
    unique case (mode)
      BUS_ON:  bclk_en = 1'b1;
      BUS_DYN: bclk_en = bus_busy;
      default: bclk_en = 1'b0;  // off and the reserved code
    endcase
  end

  assign pclk_en = pmode | bus_busy;
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
  import clkgen_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int NUM_SRC = 8,
  parameter int DIV_W   = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_busy,
  output logic [NUM_CH-1:0]  clk_out,
  output logic               bclk_en,
  output logic               pclk_en
);
  localparam int SEL_W = $clog2(NUM_SRC);
  localparam int CFG_W = 2 + SEL_W + DIV_W;
  localparam int CTL_W = 4 + NUM_SRC;

  logic [CTL_W-1:0]        ctl_q;
  logic [NUM_CH*CFG_W-1:0] cfg_q;
  logic [NUM_SRC-1:0]      lvl;
  logic [NUM_SRC-1:0]      tick;
  logic [NUM_CH-1:0]       div_raw;
  logic [NUM_CH-1:0]       byp_raw;

  clkgen_regs #(
    .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .DIV_W(DIV_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctl_q(ctl_q), .cfg_q(cfg_q)
  );

  clkgen_src_cond #(.NUM_SRC(NUM_SRC)) u_src (
    .clk(clk), .rst(rst), .src_in(src_in),
    .inv(ctl_q[CTL_IINV_LSB +: NUM_SRC]), .lvl(lvl), .tick(tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CFG_W-1:0] cfg;
    assign cfg = cfg_q[c*CFG_W +: CFG_W];

    clkgen_divider #(.NUM_SRC(NUM_SRC), .DIV_W(DIV_W)) u_div (
      .clk(clk), .rst(rst), .run(ctl_q[CTL_RUN]),
      .lvl(lvl), .tick(tick),
      .cfg_sel(cfg[CFG_SEL_LSB +: SEL_W]),
      .cfg_divm1(cfg[CFG_SEL_LSB+SEL_W +: DIV_W]),
      .div_o(div_raw[c]), .byp_o(byp_raw[c])
    );

    assign clk_out[c] = cfg[CFG_OINV] ^ (cfg[CFG_BYP] ? byp_raw[c] : div_raw[c]);
  end

  clkgen_gate u_gate (
    .bmode(ctl_q[CTL_BMODE_LSB +: 2]), .pmode(ctl_q[CTL_PMODE]),
    .bus_busy(bus_busy), .bclk_en(bclk_en), .pclk_en(pclk_en)
  );
endmodule

// File: rtl/clkgen_checker.sv
module clkgen_checker #(
  parameter int NUM_CH  = 2,
  parameter int NUM_SRC = 8,
  parameter int DIV_W   = 8,
  parameter int ADDR_W  = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     reg_we,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [4+NUM_SRC-1:0]     wr_ctl,
  input logic [4+NUM_SRC-1:0]     ctl_q,
  input logic [NUM_CH*(2+$clog2(NUM_SRC)+DIV_W)-1:0] cfg_q,
  input logic [NUM_CH-1:0]        div_raw,
  input logic                     bus_busy,
  input logic                     bclk_en,
  input logic                     pclk_en
);
  localparam int CTRL_WORD = 2 * NUM_CH;

  // R10: run bit low freezes every divided level
  a_r10_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[2] |=> $stable(div_raw));

  // R3: control write lands on the next edge
  a_r3_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_W'(CTRL_WORD)) |=> (ctl_q == $past(wr_ctl)));

  // R2: odd word writes touch nothing
  a_r2_odd_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr[0]) |=> ($stable(cfg_q) && $stable(ctl_q)));

  // R12: off and reserved codes keep the bus gate closed
  a_r12_bus_off: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[1] == 1'b0) |-> !bclk_en);

  // R12: always-on code opens the bus gate
  a_r12_bus_on: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[1:0] == 2'b11) |-> bclk_en);

  // R13: peripheral gate closed only when dynamic and idle
  a_r13_pclk_idle: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[3] && !bus_busy) |-> !pclk_en);

  a_r13_pclk_open: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[3] || bus_busy) |-> pclk_en);
endmodule

bind clkgen_top clkgen_checker #(
  .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .DIV_W(DIV_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .wr_ctl(reg_wdata[4+NUM_SRC-1:0]), .ctl_q(ctl_q), .cfg_q(cfg_q),
  .div_raw(div_raw), .bus_busy(bus_busy), .bclk_en(bclk_en), .pclk_en(pclk_en)
);

// File: tb/tb_clkgen_top.sv
module tb_clkgen_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  logic [7:0]  src = '0;
  logic        busy = 1'b0;
  wire  [1:0]  cko;
  wire         bclk, pclk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  clkgen_top dut (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .src_in(src), .bus_busy(busy), .clk_out(cko),
    .bclk_en(bclk), .pclk_en(pclk)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Source k: one cycle high every 4+k cycles
  initial begin
    int ph[8];
    for (int k = 0; k < 8; k++) ph[k] = k;
    forever begin
      @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        ph[k] = (ph[k] + 1 == 4 + k) ? 0 : ph[k] + 1;
        src[k] = (ph[k] == 0);
      end
    end
  end

  typedef struct packed {
    logic        ch;
    logic [2:0]  sel;
    logic [7:0]  divm1;
    logic        oinv;
    logic        iinv;
    logic        byp;
    logic [15:0] hi;
    logic [15:0] lo;
  } vec_t;

  // Source k period = 4+k cycles; expected lengths in system cycles
  localparam vec_t VECS[10] = '{
    '{1'b0, 3'd0, 8'd0, 1'b0, 1'b0, 1'b0, 16'd1,  16'd3},   // N=1 follows src
    '{1'b0, 3'd0, 8'd0, 1'b0, 1'b1, 1'b0, 16'd3,  16'd1},   // input invert
    '{1'b0, 3'd2, 8'd1, 1'b0, 1'b0, 1'b0, 16'd6,  16'd6},   // N=2
    '{1'b0, 3'd3, 8'd2, 1'b0, 1'b0, 1'b0, 16'd14, 16'd7},   // N=3
    '{1'b1, 3'd5, 8'd3, 1'b0, 1'b0, 1'b0, 16'd18, 16'd18},  // N=4, channel 1
    '{1'b1, 3'd7, 8'd4, 1'b0, 1'b0, 1'b0, 16'd33, 16'd22},  // N=5
    '{1'b1, 3'd1, 8'd2, 1'b1, 1'b0, 1'b0, 16'd5,  16'd10},  // N=3 inverted
    '{1'b0, 3'd4, 8'd5, 1'b0, 1'b0, 1'b1, 16'd1,  16'd7},   // bypass
    '{1'b1, 3'd6, 8'd0, 1'b1, 1'b0, 1'b1, 16'd9,  16'd1},   // bypass inverted
    '{1'b0, 3'd1, 8'd6, 1'b0, 1'b0, 1'b0, 16'd20, 16'd15}   // N=7
  };

  function automatic logic [31:0] cfgw(input logic [2:0] sel, input logic [7:0] dm1,
                                       input logic oinv, input logic byp);
    return {19'd0, dm1, sel, oinv, byp};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 4'(a);
    #1 d = rdata;
  endtask

  task automatic wait_for(input int ch, input logic v, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      if (cko[ch] === v) begin ok = 1'b1; return; end
      @(negedge clk);
    end
  endtask

  task automatic measure(input int ch, input int exp_hi, input int exp_lo, input string req);
    bit ok, all;
    int n;
    all = 1'b1;
    wait_for(ch, 1'b0, ok); all &= ok;
    wait_for(ch, 1'b1, ok); all &= ok;
    wait_for(ch, 1'b0, ok); all &= ok;
    wait_for(ch, 1'b1, ok); all &= ok;
    if (!all) begin
      check(1'b0, req, "output never toggled", 0, 1);
      return;
    end
    n = 0;
    while (cko[ch] === 1'b1 && n < 6000) begin n++; @(negedge clk); end
    check(n == exp_hi, req, "high length", n, exp_hi);
    n = 0;
    while (cko[ch] === 1'b0 && n < 6000) begin n++; @(negedge clk); end
    check(n == exp_lo, req, "low length", n, exp_lo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=finished", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit ok;
    int t0, n;
    string req;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(0, d); check(d == 0, "R1", "cfg0 after reset", d, 0);
    rd(2, d); check(d == 0, "R1", "cfg1 after reset", d, 0);
    rd(4, d); check(d == 0, "R1", "ctrl after reset", d, 0);
    check(cko == 2'b00, "R1", "clk_out after reset", cko, 0);
    check(bclk == 1'b0, "R1", "bclk_en after reset", bclk, 0);

    // R2: address map, odd words ignored
    wr(0, 32'h1234);
    wr(1, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    rd(1, d); check(d == 0, "R2", "odd word 1 reads zero", d, 0);
    rd(3, d); check(d == 0, "R2", "odd word 3 reads zero", d, 0);
    rd(0, d); check(d == 32'h1234, "R2", "cfg0 untouched by odd writes", d, 32'h1234);
    rd(2, d); check(d == 0, "R2", "cfg1 untouched", d, 0);
    rd(9, d); check(d == 0, "R2", "unmapped word 9", d, 0);

    // R3: field readback
    wr(2, 32'hFFFF_FFFF);
    rd(2, d); check(d == 32'h1FFF, "R3", "cfg1 all ones", d, 32'h1FFF);
    wr(2, cfgw(3'd5, 8'd255, 1'b0, 1'b1));
    rd(2, d); check(d[12:5] == 8'd255, "R3", "divisor field 255", d[12:5], 255);
    wr(4, 32'hFFFF_FFFF);
    rd(4, d); check(d == 32'hFFF, "R3", "ctrl all ones", d, 32'hFFF);
    wr(4, 0); wr(2, 0); wr(0, 0);

    // Vector table: R4 R5 R6 (source select, per channel) R7 R8 R9
    for (int v = 0; v < 10; v++) begin
      vec_t e;
      e = VECS[v];
      wr(4, 32'h4 | (32'(e.iinv) << (4 + e.sel)));
      wr(e.ch ? 2 : 0, cfgw(e.sel, e.divm1, e.oinv, e.byp));
      if (e.byp)            req = "R9";
      else if (e.oinv)      req = "R8";
      else if (e.iinv)      req = "R7";
      else if (e.divm1[0])  req = "R4";
      else                  req = "R5";
      measure(int'(e.ch), int'(e.hi), int'(e.lo), req);
    end

    // R4: largest divisor, 256 on channel 1 from source 0 (period 4)
    wr(4, 32'h4);
    wr(2, cfgw(3'd0, 8'd255, 1'b0, 1'b0));
    measure(1, 512, 512, "R4");

    // R11: divisor change mid-period lets the current period finish
    wr(0, cfgw(3'd0, 8'd7, 1'b0, 1'b0));
    measure(0, 16, 16, "R11");
    t0 = cyc;
    repeat (3) @(negedge clk);
    wr(0, cfgw(3'd0, 8'd1, 1'b0, 1'b0));
    wait_for(0, 1'b0, ok);
    n = cyc - t0; check(ok && n == 16, "R11", "high phase keeps old length", n, 16);
    t0 = cyc;
    wait_for(0, 1'b1, ok);
    n = cyc - t0; check(ok && n == 16, "R11", "low phase keeps old length", n, 16);
    t0 = cyc;
    wait_for(0, 1'b0, ok);
    n = cyc - t0; check(ok && n == 4, "R11", "new divisor after terminal", n, 4);

    // R10: stop holds the output; R9 bypass still runs while stopped
    wr(0, cfgw(3'd0, 8'd3, 1'b0, 1'b0));
    measure(0, 8, 8, "R10");
    wr(4, 32'h0);
    begin
      logic held;
      bit same;
      held = cko[0];
      same = 1'b1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (cko[0] !== held) same = 1'b0;
      end
      check(same, "R10", "output held while stopped", cko[0], held);
    end
    wr(0, cfgw(3'd0, 8'd3, 1'b0, 1'b1));
    measure(0, 1, 3, "R9");
    wr(0, cfgw(3'd0, 8'd3, 1'b0, 1'b0));
    wr(4, 32'h4);
    measure(0, 8, 8, "R10");

    // R12: bus-clock gate modes
    busy = 1'b1;
    wr(4, 32'h0); check(bclk == 1'b0, "R12", "mode 0 busy", bclk, 0);
    wr(4, 32'h1); check(bclk == 1'b0, "R12", "reserved mode 1 busy", bclk, 0);
    wr(4, 32'h2); check(bclk == 1'b1, "R12", "dynamic busy", bclk, 1);
    @(negedge clk); busy = 1'b0;
    #1 check(bclk == 1'b0, "R12", "dynamic idle", bclk, 0);
    wr(4, 32'h3); check(bclk == 1'b1, "R12", "always on idle", bclk, 1);

    // R13: peripheral-clock gate
    wr(4, 32'h0); check(pclk == 1'b0, "R13", "dynamic idle", pclk, 0);
    @(negedge clk); busy = 1'b1;
    #1 check(pclk == 1'b1, "R13", "dynamic busy", pclk, 1);
    @(negedge clk); busy = 1'b0;
    wr(4, 32'h8); check(pclk == 1'b1, "R13", "always on idle", pclk, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule